// File: doc/BRIEF.md
# ADC Buffer-Full Flag Controller

This block keeps the result-ready status for six converter channels that two processors share. The channels are grouped in three pairs. When a pair reports a finished conversion, the block latches both samples of that pair and raises both buffer-full flags on the same clock edge. The flags appear in the low bits of a 16-bit control word. Both processors can read this word, and neither can write the flag bits.

Each processor has its own read port, made of a strobe and a channel number. A read returns the latched sample one cycle later and drops that channel's flag. Each pair has its own interrupt enable, and a single global mask can block all interrupts. The interrupt line is a registered OR over the pairs of (flag of either channel AND the pair enable), suppressed while the mask is high. The conversion itself happens outside the block.

Top module: `adc_bf_flag_ctrl`

## Requirements
- R1: While reset is high and in the cycle after it falls, ctrl_o, irq_o, rda_data_o and rdb_data_o are all zero.
- R2: A high pair_rdy_i[p] at a clock edge sets flag bits 2p and 2p+1 of ctrl_o together on that edge. At the same edge it latches sample fields 2p and 2p+1 of smp_i, where field c is bits c*DATA_W upward.
- R3: A read on port A (rda_en_i high, rda_ch_i = c with c in 0..5) clears flag bit c at the edge. From the next cycle, rda_data_o shows the sample that was stored before that edge.
- R4: Port B (rdb_en_i, rdb_ch_i, rdb_data_o) works exactly like port A, and either port can clear any flag. Two reads of the same channel, one on each port, both return the same sample.
- R5: If a pair strobe and a clearing read reach a channel on the same edge, the flag stays set and the new sample is stored. The read returns the previous sample.
- R6: A read whose channel number is 6 or 7 changes no flag and returns zero.
- R7: irq_o is updated one cycle after the flags. Its value is 1 when glb_mask_i is 0 and, for some pair p, pair_ie_i[p] is 1 and flag 2p or flag 2p+1 is set; otherwise it is 0.
- R8: Bits 15..6 of ctrl_o are always zero, and no input can write the flag bits.
- R9: A flag with no strobe and no read on its channel keeps its value. A port that is not reading outputs zero data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pair_rdy_i | input | 3 | Per-pair sample-ready strobe |
| smp_i | input | 72 | Six sample fields, channel c at bits c*12 upward |
| rda_en_i | input | 1 | Port A read strobe |
| rda_ch_i | input | 3 | Port A channel number |
| rdb_en_i | input | 1 | Port B read strobe |
| rdb_ch_i | input | 3 | Port B channel number |
| pair_ie_i | input | 3 | Per-pair interrupt enable |
| glb_mask_i | input | 1 | Global interrupt mask, 1 blocks |
| ctrl_o | output | 16 | Control word, flags in bits 5..0 |
| irq_o | output | 1 | Registered interrupt request |
| rda_data_o | output | 12 | Port A read data |
| rdb_data_o | output | 12 | Port B read data |

## Verification
The bench uses the default parameters: three pairs, 12-bit samples and a 3-bit channel number. With this setup the two unused channel codes can be driven, and every combination of pair pattern, enable set and mask can be swept. The sweep covers 8 flag patterns × 8 enable sets × 2 mask values. Directed sequences cover collisions between a strobe and a read, reads on both ports at once, and out-of-range reads. After them comes a long pseudo-random run, checked cycle by cycle against an arithmetic model.

// File: rtl/adc_bf_pkg.sv
package adc_bf_pkg;
  parameter int unsigned CTRL_W_DEF = 16;

  // Reduce per-channel flags to one bit per pair.
  function automatic logic [7:0] pair_or(input logic [15:0] fl, input int unsigned npairs);
    logic [7:0] r;
    r = '0;
    for (int unsigned p = 0; p < npairs && p < 8; p++) r[p] = fl[2*p] | fl[2*p+1];
    return r;
  endfunction
endpackage

// File: rtl/adc_bf_pair_cap.sv
module adc_bf_pair_cap #(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rdy_i,
  input  logic [2*DATA_W-1:0] smp_i,
  input  logic [1:0]        clr_i,
  output logic [1:0]        flag_o,
  output logic [2*DATA_W-1:0] store_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      flag_o  <= '0;
      store_o <= '0;
    end else if (rdy_i) begin
      flag_o  <= 2'b11;
      store_o <= smp_i;
    end else begin
      flag_o  <= flag_o & ~clr_i;
    end
  end

  // R2
  pair_set_chk: assert property (@(posedge clk) disable iff (rst)
    rdy_i |=> (flag_o == 2'b11));
  // R5
  set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (rdy_i && clr_i != 2'b00) |=> (flag_o == 2'b11));
  // R3
  clr_lo_chk: assert property (@(posedge clk) disable iff (rst)
    (!rdy_i && clr_i[0]) |=> !flag_o[0]);
  // R4
  clr_hi_chk: assert property (@(posedge clk) disable iff (rst)
    (!rdy_i && clr_i[1]) |=> !flag_o[1]);
  // R9
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!rdy_i && clr_i == 2'b00) |=> $stable(flag_o));
endmodule

// File: rtl/adc_bf_rd_port.sv
module adc_bf_rd_port #(
  parameter int DATA_W = 12,
  parameter int NCH    = 6,
  parameter int CHW    = 3
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  en_i,
  input  logic [CHW-1:0]        ch_i,
  input  logic [NCH*DATA_W-1:0] store_i,
  output logic [DATA_W-1:0]     data_o
);
  logic hit;
  assign hit = en_i && (int'(ch_i) < NCH);

  always_ff @(posedge clk) begin
    if (rst || !hit) data_o <= '0;
    else             data_o <= store_i[int'(ch_i)*DATA_W +: DATA_W];
  end

  // R6
  bad_ch_chk: assert property (@(posedge clk) disable iff (rst)
    (en_i && int'(ch_i) >= NCH) |=> (data_o == '0));
  // R9
  idle_chk: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> (data_o == '0));
endmodule

// File: rtl/adc_bf_irq.sv
module adc_bf_irq #(
  parameter int NUM_PAIRS = 3
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [2*NUM_PAIRS-1:0] flag_i,
  input  logic [NUM_PAIRS-1:0]   ie_i,
  input  logic                   mask_i,
  output logic                   irq_o
);
  logic [NUM_PAIRS-1:0] pair_any;

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
    assign pair_any[p] = flag_i[2*p] | flag_i[2*p+1];
  end

  always_ff @(posedge clk) begin
    if (rst) irq_o <= 1'b0;
    else     irq_o <= (|(pair_any & ie_i)) & ~mask_i;
  end

  // R7
  masked_chk: assert property (@(posedge clk) disable iff (rst)
    mask_i |=> !irq_o);
  // R7
  fire_chk: assert property (@(posedge clk) disable iff (rst)
    (!mask_i && (flag_i[0] || flag_i[1]) && ie_i[0]) |=> irq_o);
  // R7
  quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (flag_i == '0) |=> !irq_o);
endmodule

// File: rtl/adc_bf_flag_ctrl.sv
module adc_bf_flag_ctrl #(
  parameter int NUM_PAIRS = 3,
  parameter int DATA_W    = 12,
  parameter int CTRL_W    = adc_bf_pkg::CTRL_W_DEF,
  localparam int NCH      = 2 * NUM_PAIRS,
  localparam int CHW      = $clog2(NCH)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NUM_PAIRS-1:0]  pair_rdy_i,
  input  logic [NCH*DATA_W-1:0] smp_i,
  input  logic                  rda_en_i,
  input  logic [CHW-1:0]        rda_ch_i,
  input  logic                  rdb_en_i,
  input  logic [CHW-1:0]        rdb_ch_i,
  input  logic [NUM_PAIRS-1:0]  pair_ie_i,
  input  logic                  glb_mask_i,
  output logic [CTRL_W-1:0]     ctrl_o,
  output logic                  irq_o,
  output logic [DATA_W-1:0]     rda_data_o,
  output logic [DATA_W-1:0]     rdb_data_o
);
  logic [NCH-1:0]        flags;
  logic [NCH-1:0]        clr;
  logic [NCH*DATA_W-1:0] store;

  for (genvar c = 0; c < NCH; c++) begin : g_clr
    assign clr[c] = (rda_en_i && int'(rda_ch_i) == c) || (rdb_en_i && int'(rdb_ch_i) == c);
  end

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_cap
    adc_bf_pair_cap #(.DATA_W(DATA_W)) cap_i (
      .clk     (clk),
      .rst     (rst),
      .rdy_i   (pair_rdy_i[p]),
      .smp_i   (smp_i[2*p*DATA_W +: 2*DATA_W]),
      .clr_i   (clr[2*p +: 2]),
      .flag_o  (flags[2*p +: 2]),
      .store_o (store[2*p*DATA_W +: 2*DATA_W])
    );
  end

  adc_bf_rd_port #(.DATA_W(DATA_W), .NCH(NCH), .CHW(CHW)) port_a_i (
    .clk(clk), .rst(rst), .en_i(rda_en_i), .ch_i(rda_ch_i),
    .store_i(store), .data_o(rda_data_o)
  );

  adc_bf_rd_port #(.DATA_W(DATA_W), .NCH(NCH), .CHW(CHW)) port_b_i (
    .clk(clk), .rst(rst), .en_i(rdb_en_i), .ch_i(rdb_ch_i),
    .store_i(store), .data_o(rdb_data_o)
  );

  adc_bf_irq #(.NUM_PAIRS(NUM_PAIRS)) irq_i (
    .clk(clk), .rst(rst), .flag_i(flags), .ie_i(pair_ie_i),
    .mask_i(glb_mask_i), .irq_o(irq_o)
  );

  assign ctrl_o = {{(CTRL_W-NCH){1'b0}}, flags};

  // R1
  rst_clear_chk: assert property (@(posedge clk)
    $past(rst) |-> (ctrl_o == '0 && !irq_o));
  // R6
  bad_rd_chk: assert property (@(posedge clk) disable iff (rst)
    (pair_rdy_i == '0 && !rdb_en_i && rda_en_i && int'(rda_ch_i) >= NCH) |=> $stable(ctrl_o));
endmodule

// File: tb/adc_bf_flag_ctrl_tb_top.sv
module adc_bf_flag_ctrl_tb_top;
  localparam int NP = 3, NCH = 6, DW = 12, CW = 16;

  logic clk = 1'b0;
  logic rst;
  logic [NP-1:0] pair_rdy;
  logic [NCH*DW-1:0] smp;
  logic ra_en, rb_en;
  logic [2:0] ra_ch, rb_ch;
  logic [NP-1:0] ie;
  logic mask;
  logic [CW-1:0] ctrl;
  logic irq;
  logic [DW-1:0] ra_d, rb_d;

  int errors = 0, checks = 0, seq = 0;
  logic [NCH-1:0] e_flags;
  logic [DW-1:0] e_smp [NCH];

  always #5 clk = ~clk;

  adc_bf_flag_ctrl dut_i (
    .clk(clk), .rst(rst), .pair_rdy_i(pair_rdy), .smp_i(smp),
    .rda_en_i(ra_en), .rda_ch_i(ra_ch), .rdb_en_i(rb_en), .rdb_ch_i(rb_ch),
    .pair_ie_i(ie), .glb_mask_i(mask), .ctrl_o(ctrl), .irq_o(irq),
    .rda_data_o(ra_d), .rdb_data_o(rb_d)
  );

  function automatic logic [DW-1:0] val(input int s, input int c);
    return DW'((s * 13 + c * 301 + 5) & 12'hFFF);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // Called at a negedge; drives, lets one edge pass, checks at the next negedge.
  task automatic step(input logic [2:0] rdy, input logic ae, input logic [2:0] ac,
                      input logic be, input logic [2:0] bc);
    logic e_irq;
    logic [DW-1:0] e_a, e_b;
    logic [NCH-1:0] nf;
    seq++;
    pair_rdy = rdy; ra_en = ae; ra_ch = ac; rb_en = be; rb_ch = bc;
    for (int c = 0; c < NCH; c++) smp[c*DW +: DW] = val(seq, c);
    e_irq = 1'b0;
    for (int p = 0; p < NP; p++)
      if (ie[p] && (e_flags[2*p] || e_flags[2*p+1])) e_irq = 1'b1;
    e_irq = e_irq & ~mask;
    e_a = (ae && ac < 6) ? e_smp[ac] : '0;
    e_b = (be && bc < 6) ? e_smp[bc] : '0;
    nf = e_flags;
    if (ae && ac < 6) nf[ac] = 1'b0;
    if (be && bc < 6) nf[bc] = 1'b0;
    for (int p = 0; p < NP; p++)
      if (rdy[p]) begin
        nf[2*p] = 1'b1; nf[2*p+1] = 1'b1;
        e_smp[2*p] = val(seq, 2*p); e_smp[2*p+1] = val(seq, 2*p+1);
      end
    e_flags = nf;
    @(negedge clk);
    chk("R2 R3 R4 R5 R6 R8 R9 ctrl", 32'(ctrl), 32'({10'd0, e_flags}));
    chk("R7 irq", 32'(irq), 32'(e_irq));
    chk("R3 R5 R6 R9 portA", 32'(ra_d), 32'(e_a));
    chk("R4 R5 R6 R9 portB", 32'(rb_d), 32'(e_b));
  endtask

  task automatic clear_all();
    for (int k = 0; k < NP; k++) step(3'b000, 1'b1, 3'(2*k), 1'b1, 3'(2*k+1));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [15:0] lf;
    rst = 1'b1; pair_rdy = '0; smp = '0; ra_en = 0; rb_en = 0; ra_ch = '0; rb_ch = '0;
    ie = '0; mask = 1'b0;
    e_flags = '0;
    for (int c = 0; c < NCH; c++) e_smp[c] = '0;
    pair_rdy = 3'b111; ra_en = 1'b1; // activity during reset must be ignored
    repeat (3) @(negedge clk);
    chk("R1 ctrl in reset", 32'(ctrl), 32'd0);
    rst = 1'b0; pair_rdy = '0; ra_en = 1'b0;
    @(negedge clk);
    chk("R1 ctrl", 32'(ctrl), 32'd0);
    chk("R1 irq", 32'(irq), 32'd0);
    chk("R1 portA", 32'(ra_d), 32'd0);
    chk("R1 portB", 32'(rb_d), 32'd0);

    // R2 R3 R4: each pair, read its channels one per port
    ie = 3'b111;
    for (int p = 0; p < NP; p++) begin
      step(3'(1 << p), 0, 0, 0, 0);
      step(0, 0, 0, 0, 0);
      step(0, 1, 3'(2*p), 0, 0);
      step(0, 0, 0, 1, 3'(2*p+1));
      step(0, 0, 0, 0, 0);
    end
    // R4: both ports on the same channel
    step(3'b111, 0, 0, 0, 0);
    for (int c = 0; c < NCH; c++) step(0, 1, 3'(c), 1, 3'(c));
    // R5: collision of strobe and read
    for (int c = 0; c < NCH; c++) begin
      step(3'(1 << (c / 2)), (c % 2) == 0, 3'(c), (c % 2) == 1, 3'(c));
      step(0, 1, 3'(c), 0, 0);
    end
    clear_all();
    // R6: out-of-range channel numbers
    step(3'b101, 0, 0, 0, 0);
    step(0, 1, 3'd6, 1, 3'd7);
    step(0, 1, 3'd7, 0, 0);
    clear_all();
    // R7: exhaustive enable/mask/pattern sweep
    for (int m = 0; m < 2; m++)
      for (int e = 0; e < 8; e++)
        for (int pat = 0; pat < 8; pat++) begin
          mask = m[0]; ie = 3'(e);
          clear_all();
          step(3'(pat), 0, 0, 0, 0);
          step(0, 0, 0, 0, 0);
        end
    // Mixed pseudo-random traffic
    lf = 16'hACE1;
    for (int i = 0; i < 400; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      ie = lf[2:0]; mask = (lf[15:13] == 3'd0);
      step(lf[5:3] & {3{lf[6]}}, lf[7], lf[10:8], lf[11], lf[14:12]);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule